// File: doc/BRIEF.md
# Bank Conflict Serializer

This block sits in front of a 32-bank word-wide scratchpad and turns one warp-wide request into a series of conflict-free passes. The request carries 32 lanes. Each lane has an active bit and a byte address. A word lives in bank (address/4) mod 32, at a row given by the address divided by 128. When several lanes need different words from the same bank, the bank can serve only one of them per cycle. The block therefore issues one pass per cycle. In each pass every bank receives at most one row address and one enable. It keeps going until every active lane has been served.

Lanes that ask for the identical word are merged into a single bank access. Merged lanes do not add to the pass count. Within each bank the lowest-numbered pending lane decides which word goes first. The block accepts a request through a ready/valid handshake and holds ready low while it works through the passes. In the last pass it pulses `done` together with the conflict degree, which is the number of passes issued. The scratchpad arrays and the data path back to the lanes sit outside this block. `lane_grant` shows which lanes each pass serves.

Top module: `scr_serializer`

## Requirements
- R1: A lane with byte address a targets bank (a/4) mod 32 and row a/128. In a pass that serves the lane, that bank's slice of `bank_row` (bits 9*b+8 down to 9*b) carries that row.
- R2: In each pass a bank is enabled only if at least one granted lane maps to it, and every granted lane maps to an enabled bank at the row that bank drives.
- R3: Pending lanes that address the same word of a bank are granted in the same pass and do not raise the degree.
- R4: In each bank the row served first is the one of the lowest-numbered pending lane; later passes follow the same rule over the lanes still pending.
- R5: The passes come on consecutive cycles, the first one cycle after acceptance. Their number, reported as `degree`, equals the largest count of distinct words requested from any single bank.
- R6: `req_ready` is high when idle. It is low from the cycle after acceptance until the last pass, and it is high again in the cycle that carries `done`.
- R7: Inactive lanes are never granted and have no effect on bank enables, rows or degree.
- R8: A request with no active lanes produces `done` one cycle after acceptance, with `degree` 0, no bank enabled and no lane granted.
- R9: `done` is a one-cycle pulse that coincides with the last pass, and `degree` is valid in that cycle.
- R10: During reset `req_ready` is high while `done`, `bank_en` and `lane_grant` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_active | input | LANES (32) | Per-lane active bits |
| req_addr | input | LANES*ADDR_W (512) | Per-lane byte addresses, lane l at bits 16*l+15:16*l |
| bank_en | output | BANKS (32) | Per-bank enable for the current pass |
| bank_row | output | BANKS*ROW_W (288) | Per-bank row address for the current pass |
| lane_grant | output | LANES (32) | Lanes served in the current pass |
| done | output | 1 | Last pass of the request |
| degree | output | DEG_W (6) | Number of passes the request took |

## Verification
The main function is exercised with several address patterns. An all-inactive request checks the empty case. Unit stride fills every bank once and must take a single pass. Double stride gives two passes, and a pure column walk puts all 32 lanes on one bank and gives 32 passes. A padded 33-word stride lands every lane in a different bank, which separates a correct bank index from one that uses the wrong address bits. An all-same-address request and a half-broadcast request tell merging apart from serialization. A sparse request with lanes deliberately out of order in one bank exposes the priority order. Odd inactive lanes that collide with active ones show whether the active bit is honoured. Seeded random mixes then compare every pass against a behavioural model.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } scr_state_t;
endpackage

// File: rtl/scr_lane_map.sv
// Splits each lane's word address into bank index (low bits) and row (high bits).
module scr_lane_map #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int WORD_W = 14,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = WORD_W - BANK_W
) (
  input  logic [LANES*WORD_W-1:0] word_flat,
  output logic [LANES*BANK_W-1:0] bank_flat,
  output logic [LANES*ROW_W-1:0]  row_flat
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bank_flat[l*BANK_W +: BANK_W] = word_flat[l*WORD_W +: BANK_W];
    assign row_flat[l*ROW_W +: ROW_W]    = word_flat[l*WORD_W + BANK_W +: ROW_W];
  end
endmodule

// File: rtl/scr_bank_pick.sv
// For one bank: finds the lowest pending lane mapped to it and returns its row.
module scr_bank_pick #(
  parameter int LANES   = 32,
  parameter int BANKS   = 32,
  parameter int ROW_W   = 9,
  parameter int BANK_ID = 0,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*BANK_W-1:0] bank_flat,
  input  logic [LANES*ROW_W-1:0]  row_flat,
  output logic                    sel_valid,
  output logic [ROW_W-1:0]        sel_row
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  always_comb begin
    sel_valid = 1'b0;
    sel_row   = '0;
    // descending scan: the last match written is the lowest lane
    for (int l = LANES - 1; l >= 0; l--) begin
      if (pend[l] && (bank_flat[l*BANK_W +: BANK_W] == MY_BANK)) begin
        sel_valid = 1'b1;
        sel_row   = row_flat[l*ROW_W +: ROW_W];
      end
    end
  end
endmodule

// File: rtl/scr_serializer.sv
module scr_serializer
  import scr_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int BANKS      = 32,
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 16,
  localparam int OFF_W  = $clog2(WORD_BYTES),
  localparam int BANK_W = $clog2(BANKS),
  localparam int WORD_W = ADDR_W - OFF_W,
  localparam int ROW_W  = WORD_W - BANK_W,
  localparam int DEG_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic [BANKS-1:0]        bank_en,
  output logic [BANKS*ROW_W-1:0]  bank_row,
  output logic [LANES-1:0]        lane_grant,
  output logic                    done,
  output logic [DEG_W-1:0]        degree
);
  scr_state_t          state_q;
  logic [LANES-1:0]    pend_q;
  logic [DEG_W-1:0]    pass_cnt_q;
  logic [WORD_W-1:0]   word_q [LANES];
  logic                take;

  logic [LANES*WORD_W-1:0] word_flat;
  logic [LANES*BANK_W-1:0] bank_flat;
  logic [LANES*ROW_W-1:0]  row_flat;
  logic [BANKS-1:0]        sel_v;
  logic [ROW_W-1:0]        sel_row [BANKS];
  logic [BANKS*ROW_W-1:0]  sel_row_flat;
  logic [LANES-1:0]        grant_c;
  logic [LANES-1:0]        remain_c;
  logic [DEG_W-1:0]        cnt_nxt;

  assign req_ready = (state_q == ST_IDLE);
  assign take      = (state_q == ST_IDLE) && req_valid;

  // word addresses: no reset, written only at acceptance
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (take) word_q[l] <= req_addr[l*ADDR_W + OFF_W +: WORD_W];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_flat
    assign word_flat[l*WORD_W +: WORD_W] = word_q[l];
  end

  scr_lane_map #(
    .LANES (LANES),
    .BANKS (BANKS),
    .WORD_W(WORD_W)
  ) u_map (
    .word_flat(word_flat),
    .bank_flat(bank_flat),
    .row_flat (row_flat)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    scr_bank_pick #(
      .LANES  (LANES),
      .BANKS  (BANKS),
      .ROW_W  (ROW_W),
      .BANK_ID(b)
    ) u_pick (
      .pend     (pend_q),
      .bank_flat(bank_flat),
      .row_flat (row_flat),
      .sel_valid(sel_v[b]),
      .sel_row  (sel_row[b])
    );
    assign sel_row_flat[b*ROW_W +: ROW_W] = sel_row[b];
  end

  // a lane is served when its bank picked the same row (broadcast merge)
  for (genvar l = 0; l < LANES; l++) begin : g_grant
    logic [BANK_W-1:0] lb;
    assign lb         = bank_flat[l*BANK_W +: BANK_W];
    assign grant_c[l] = pend_q[l] && sel_v[lb] &&
                        (row_flat[l*ROW_W +: ROW_W] == sel_row[lb]);
  end

  assign remain_c = pend_q & ~grant_c;
  assign cnt_nxt  = pass_cnt_q + {{(DEG_W-1){1'b0}}, |grant_c};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      pend_q     <= '0;
      pass_cnt_q <= '0;
      bank_en    <= '0;
      bank_row   <= '0;
      lane_grant <= '0;
      done       <= 1'b0;
      degree     <= '0;
    end else begin
      done       <= 1'b0;
      bank_en    <= '0;
      lane_grant <= '0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            pend_q     <= req_active;
            pass_cnt_q <= '0;
            state_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          bank_en    <= sel_v;
          bank_row   <= sel_row_flat;
          lane_grant <= grant_c;
          pend_q     <= remain_c;
          pass_cnt_q <= cnt_nxt;
          if (remain_c == '0) begin
            done    <= 1'b1;
            degree  <= cnt_nxt;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scr_serializer_chk.sv
module scr_serializer_chk #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int DEG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [BANKS-1:0] bank_en,
  input logic [LANES-1:0] lane_grant,
  input logic             done,
  input logic [DEG_W-1:0] degree
);
  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_ready_back_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_en_has_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (bank_en != '0) |-> (lane_grant != '0));

  assert_grant_has_en_R2: assert property (@(posedge clk) disable iff (rst)
    (lane_grant != '0) |-> (bank_en != '0));

  assert_merge_count_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_en) <= $countones(lane_grant));

  assert_degree_bound_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(degree) <= LANES));

  assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (done && degree == '0) |-> (bank_en == '0));
endmodule

bind scr_serializer scr_serializer_chk #(
  .LANES(LANES),
  .BANKS(BANKS),
  .DEG_W(DEG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bank_en   (bank_en),
  .lane_grant(lane_grant),
  .done      (done),
  .degree    (degree)
);

// File: tb/sim_scr_serializer.sv
`timescale 1ns/1ps
module sim_scr_serializer;
  localparam int L  = 32;
  localparam int B  = 32;
  localparam int AW = 16;
  localparam int RW = 9;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [L-1:0]  req_active = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [B-1:0]  bank_en;
  logic [B*RW-1:0] bank_row;
  logic [L-1:0]  lane_grant;
  logic          done;
  logic [DW-1:0] degree;

  int total = 0;
  int bad   = 0;
  bit [31:0] t_act;
  int        t_addr [32];

  always #2.5 clk = ~clk;

  scr_serializer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .bank_en(bank_en),
    .bank_row(bank_row), .lane_grant(lane_grant), .done(done), .degree(degree)
  );

  function automatic int bankof(int a); return (a / 4) % 32; endfunction
  function automatic int rowof(int a);  return (a / 128) % 512; endfunction

  task automatic chk(input bit ok, input string r, input string what,
                     input longint a, input longint e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, a, e);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // behavioural model: per bank, lowest pending lane picks the word
  task automatic run_req(input string tag);
    bit [31:0] pd, en, gr;
    int rr [32];
    bit [31:0] q_en[$];
    bit [31:0] q_gr[$];
    int q_rw[$];
    int n, w;
    pd = t_act;
    while (pd != 0) begin
      en = 0; gr = 0;
      for (int b = 0; b < 32; b++) rr[b] = 0;
      for (int l = 0; l < 32; l++)
        if (pd[l] && !en[bankof(t_addr[l])]) begin
          en[bankof(t_addr[l])] = 1'b1;
          rr[bankof(t_addr[l])] = rowof(t_addr[l]);
        end
      for (int l = 0; l < 32; l++)
        if (pd[l] && rowof(t_addr[l]) == rr[bankof(t_addr[l])]) gr[l] = 1'b1;
      pd &= ~gr;
      q_en.push_back(en);
      q_gr.push_back(gr);
      for (int b = 0; b < 32; b++) q_rw.push_back(rr[b]);
    end
    n = q_en.size();
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    req_valid  = 1'b1;
    req_active = t_act;
    for (int l = 0; l < 32; l++) req_addr[l*AW +: AW] = t_addr[l][15:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R6", "ready after accept", req_ready, 0);
    if (n == 0) begin
      @(negedge clk);
      chk(done == 1'b1, "R8", "empty done", done, 1);
      chk(degree == 0, "R8", "empty degree", degree, 0);
      chk(bank_en == 0, "R8", "empty bank_en", bank_en, 0);
      chk(lane_grant == 0, "R7", "empty grant", lane_grant, 0);
      chk(req_ready == 1'b1, "R6", "ready with done", req_ready, 1);
    end else begin
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        chk(bank_en == q_en[k], tag, $sformatf("bank_en pass %0d", k), bank_en, q_en[k]);
        chk(lane_grant == q_gr[k], tag, $sformatf("grant pass %0d", k), lane_grant, q_gr[k]);
        for (int b = 0; b < 32; b++)
          if (q_en[k][b])
            chk(int'(bank_row[b*RW +: RW]) == q_rw[k*32+b], "R1",
                $sformatf("row bank %0d pass %0d", b, k), bank_row[b*RW +: RW], q_rw[k*32+b]);
        chk(done == (k == n-1), "R9", $sformatf("done pass %0d", k), done, (k == n-1));
        if (k == n-1) begin
          chk(int'(degree) == n, "R5", "degree", degree, n);
          chk(req_ready == 1'b1, "R6", "ready with done", req_ready, 1);
        end else begin
          chk(req_ready == 1'b0, "R6", "ready while busy", req_ready, 0);
        end
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done pulse ends", done, 0);
    chk(req_ready == 1'b1, "R6", "idle ready", req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    chk(bank_en == 0, "R10", "reset bank_en", bank_en, 0);
    chk(lane_grant == 0, "R10", "reset grant", lane_grant, 0);
    rst = 1'b0;
    @(negedge clk);

    // R8: nothing active, conflicting addresses present
    t_act = 32'h0;
    for (int l = 0; l < 32; l++) t_addr[l] = 128*l;
    run_req("R8");

    // R5: unit stride, one pass
    t_act = 32'hFFFF_FFFF;
    for (int l = 0; l < 32; l++) t_addr[l] = 32'h200 + 4*l;
    run_req("R5");

    // R5: double stride, two passes
    for (int l = 0; l < 32; l++) t_addr[l] = 8*l;
    run_req("R5");

    // R5: column walk, all on bank 3, 32 passes
    for (int l = 0; l < 32; l++) t_addr[l] = 128*l + 12;
    run_req("R5");

    // R1: padded stride, every lane its own bank
    for (int l = 0; l < 32; l++) t_addr[l] = 132*l + 8;
    run_req("R1");

    // R3: full broadcast of one word
    for (int l = 0; l < 32; l++) t_addr[l] = 32'h40;
    run_req("R3");

    // R3: two broadcast groups on bank 17
    for (int l = 0; l < 32; l++) t_addr[l] = (l < 16) ? 32'h44 : 32'h44 + 128;
    run_req("R3");

    // R4: lanes 3, 9, 20 on bank 3, rows 0, 2, 4
    t_act = 32'h0;
    t_act[3] = 1'b1; t_act[9] = 1'b1; t_act[20] = 1'b1;
    for (int l = 0; l < 32; l++) t_addr[l] = 0;
    t_addr[9] = 32'h0C + 256; t_addr[3] = 32'h0C; t_addr[20] = 32'h0C + 512;
    run_req("R4");

    // R4: reversed row order by lane index
    t_addr[3] = 32'h0C + 512; t_addr[9] = 32'h0C; t_addr[20] = 32'h0C + 256;
    run_req("R4");

    // R7: odd lanes inactive but colliding with even lanes
    t_act = 32'h5555_5555;
    for (int l = 0; l < 32; l++) t_addr[l] = (l % 2 == 0) ? 4*l : 4*(l-1) + 1024;
    run_req("R7");

    // R2: seeded random mixes
    for (int i = 0; i < 40; i++) begin
      t_act = $urandom;
      for (int l = 0; l < 32; l++) t_addr[l] = $urandom_range(0, 2047);
      run_req("R2");
    end

    summary();
    $finish;
  end
endmodule